// File: doc/BRIEF.md
# Write-Guarded Seconds Counter

This block keeps a 32-bit count of elapsed seconds and exposes it on a small register bus with 16-bit data. A one-cycle pulse on the tick input, produced elsewhere once per second, advances the count by one. Software reads the count as two 16-bit halves and can also reload it. A reload is only possible through a guarded sequence: first set a write-enable flag, then write the low half, then write the high half. Writing the high half closes the guard again.

Bus accesses happen in a single cycle. The access strobe is qualified by a write flag. Only the low byte of the address is decoded. Read data is registered and appears one cycle after the read strobe. A separate preset port lets the surrounding logic load a full starting count, for example after power-up.

Top module: `sec_rtc`

## Requirements
- R1: A read at byte offset 0x00 returns count bits 31:16, and a read at offset 0x04 returns count bits 15:0. The value appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R2: A read at offset 0x08 always returns zero. A read at any other undecoded offset also returns zero.
- R3: A write at offset 0x08 loads the write-enable flag from data bit 0. The other data bits have no effect.
- R4: While the enable flag is set, a write at offset 0x04 replaces count bits 15:0 and leaves the flag set.
- R5: While the enable flag is set, a write at offset 0x00 replaces count bits 31:16 and clears the flag.
- R6: While the enable flag is clear, writes at offsets 0x00 and 0x04 leave the count unchanged.
- R7: Each cycle with `tick_1hz` high raises the count by exactly one. The carry crosses the half boundary, and the count wraps from 0xFFFFFFFF to 0.
- R8: When an accepted count write and a tick fall in the same cycle, the written value is kept and that increment is lost. A rejected write does not suppress the tick.
- R9: Address bits above bit 7 are ignored by both reads and writes.
- R10: Synchronous reset clears the count, the enable flag and `bus_rdata`.
- R11: `preset_load` loads `preset_value` into the whole count. It takes priority over ticks and count writes, and it does not change the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| preset_load | input | 1 | Load `preset_value` into the count |
| preset_value | input | 2*DATA_W | Preset count value |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The guard is exercised with several write orders:
- writes while locked;
- a low-half write followed by a second low-half write, which shows the flag survives;
- a high-half write followed by another, which shows the flag dropped;
- control writes with bit 0 clear but other bits set.

Counting is tried with these patterns:
- bursts of ticks;
- a tick across the 16-bit carry;
- a tick at the 32-bit wrap point.

Collisions separate an accepted write that swallows a tick from a rejected write that must not. A preset applied together with a tick shows its priority. Aliased addresses with high bits set show that only the low byte is decoded.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_HI   = 8'h00;
  localparam logic [OFF_W-1:0] OFF_LO   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_CTRL = 8'h08;

  typedef enum logic [1:0] {
    REG_HI   = 2'd0,
    REG_LO   = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } rtc_reg_e;
endpackage

// File: rtl/rtc_regdec.sv
module rtc_regdec
  import rtc_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  logic             sel,
  input  logic             we,
  output rtc_reg_e         which,
  output logic             wr_hi,
  output logic             wr_lo,
  output logic             wr_ctrl,
  output logic             rd
);
  always_comb begin
    case (off)
      OFF_HI:   which = REG_HI;
      OFF_LO:   which = REG_LO;
      OFF_CTRL: which = REG_CTRL;
      default:  which = REG_NONE;
    endcase
  end

  assign wr_hi   = sel & we & (which == REG_HI);
  assign wr_lo   = sel & we & (which == REG_LO);
  assign wr_ctrl = sel & we & (which == REG_CTRL);
  assign rd      = sel & ~we;
endmodule

// File: rtl/rtc_guard.sv
module rtc_guard (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic       ctrl_bit,
  input  logic       wr_hi,
  input  logic       wr_lo,
  output logic       en_q,
  output logic [1:0] lane_ld
);
  // lane 1 = upper half, lane 0 = lower half
  assign lane_ld = {wr_hi & en_q, wr_lo & en_q};

  always_ff @(posedge clk) begin
    if (rst)           en_q <= 1'b0;
    else if (wr_ctrl)  en_q <= ctrl_bit;
    else if (lane_ld[1]) en_q <= 1'b0;
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    preset_load,
  input  logic [LANE_W*LANES-1:0] preset_value,
  input  logic                    tick,
  input  logic [LANES-1:0]        lane_ld,
  input  logic [LANE_W-1:0]       wdata,
  output logic [LANE_W*LANES-1:0] count_q
);
  localparam int CNT_W = LANE_W * LANES;

  logic [CNT_W-1:0] loaded;
  logic [CNT_W-1:0] nxt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign loaded[g*LANE_W +: LANE_W] = lane_ld[g] ? wdata : count_q[g*LANE_W +: LANE_W];
  end

  always_comb begin
    if (preset_load)   nxt = preset_value;
    else if (|lane_ld) nxt = loaded;
    else if (tick)     nxt = count_q + CNT_W'(1);
    else               nxt = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= nxt;
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_1hz,
  input  logic                preset_load,
  input  logic [2*DATA_W-1:0] preset_value,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata
);
  localparam int CNT_W = 2 * DATA_W;

  logic [OFF_W-1:0] off;
  logic             unused_addr_hi;
  rtc_reg_e         which;
  logic             wr_hi, wr_lo, wr_ctrl, rd;
  logic             en_q;
  logic [1:0]       lane_ld;
  logic [CNT_W-1:0] count_q;
  logic [DATA_W-1:0] rd_mux;

  assign off            = bus_addr[OFF_W-1:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];

  rtc_regdec u_dec (
    .off(off), .sel(bus_sel), .we(bus_we), .which(which),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ctrl(wr_ctrl), .rd(rd)
  );

  rtc_guard u_guard (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .ctrl_bit(bus_wdata[0]),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .en_q(en_q), .lane_ld(lane_ld)
  );

  rtc_counter #(.LANE_W(DATA_W), .LANES(2)) u_cnt (
    .clk(clk), .rst(rst), .preset_load(preset_load), .preset_value(preset_value),
    .tick(tick_1hz), .lane_ld(lane_ld), .wdata(bus_wdata), .count_q(count_q)
  );

  always_comb begin
    case (which)
      REG_HI:  rd_mux = count_q[CNT_W-1:DATA_W];
      REG_LO:  rd_mux = count_q[DATA_W-1:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_1hz,
  input logic                preset_load,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [2*DATA_W-1:0] count,
  input logic                en
);
  logic rd_hi, rd_ctrl, w_hi, w_lo, accepted;
  assign rd_hi    = bus_sel && !bus_we && bus_addr[7:0] == 8'h00;
  assign rd_ctrl  = bus_sel && !bus_we && bus_addr[7:0] == 8'h08;
  assign w_hi     = bus_sel && bus_we && bus_addr[7:0] == 8'h00;
  assign w_lo     = bus_sel && bus_we && bus_addr[7:0] == 8'h04;
  assign accepted = en && (w_hi || w_lo);

  AST_READ_HI: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> bus_rdata == $past(count[2*DATA_W-1:DATA_W])); // R1
  AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl |=> bus_rdata == '0); // R2
  AST_LO_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    (w_lo && en && !preset_load) |=> (count[DATA_W-1:0] == $past(bus_wdata)) && en); // R4
  AST_HI_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    (w_hi && en) |=> !en); // R5
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((w_hi || w_lo) && !en && !tick_1hz && !preset_load) |=> $stable(count)); // R6
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !accepted && !preset_load) |=> count == $past(count) + 1'b1); // R7
endmodule

bind sec_rtc sec_rtc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .preset_load(preset_load),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .count(count_q), .en(en_q)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        preset_load = 1'b0;
  logic [31:0] preset_value = '0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sec_rtc uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input bit with_tick = 0);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; tick_1hz = with_tick;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; tick_1hz = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [15:0] h, l;
    rd(16'h0000, h);
    rd(16'h0004, l);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1;
      @(negedge clk); tick_1hz = 0;
    end
  endtask

  task automatic preset(input logic [31:0] v, input bit with_tick = 0);
    @(negedge clk);
    preset_load = 1; preset_value = v; tick_1hz = with_tick;
    @(negedge clk);
    preset_load = 0; tick_1hz = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R10 rdata", {16'h0, bus_rdata}, 32'h0);
    rd32(v);
    check("R10 count", v, 32'h0);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    wr(16'h0000, 16'hAAAA);
    wr(16'h0004, 16'h5555);
    rd32(v);
    check("R6 locked", v, 32'h0);
  endtask

  task automatic t_lo_then_hi;
    logic [31:0] v;
    wr(16'h0008, 16'h0001);
    wr(16'h0004, 16'h1234);
    rd32(v); check("R3 R4 lo write", v, 32'h0000_1234);
    wr(16'h0004, 16'h4321);
    rd32(v); check("R4 flag kept", v, 32'h0000_4321);
    wr(16'h0000, 16'hBEEF);
    rd32(v); check("R5 hi write", v, 32'hBEEF_4321);
    wr(16'h0000, 16'h1111);
    wr(16'h0004, 16'h9999);
    rd32(v); check("R5 flag dropped", v, 32'hBEEF_4321);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    logic [15:0] d;
    wr(16'h0008, 16'h0001);
    wr(16'h0008, 16'h0000);
    wr(16'h0004, 16'h7777);
    rd32(v); check("R3 cleared", v, 32'hBEEF_4321);
    wr(16'h0008, 16'hFFFE);
    wr(16'h0004, 16'h7777);
    rd32(v); check("R3 bit0 only", v, 32'hBEEF_4321);
    rd(16'h0008, d); check("R2 ctrl read", {16'h0, d}, 32'h0);
    rd(16'h000C, d); check("R2 unknown read", {16'h0, d}, 32'h0);
  endtask

  task automatic t_alias;
    logic [15:0] d;
    logic [31:0] v;
    rd(16'h1200, d); check("R9 read alias", {16'h0, d}, 32'h0000_BEEF);
    wr(16'h3308, 16'h0001);
    wr(16'h7704, 16'h0F0F);
    rd32(v); check("R9 write alias", v, 32'hBEEF_0F0F);
    wr(16'h0000, 16'hBEEF);
  endtask

  task automatic t_tick;
    logic [31:0] v;
    ticks(3);
    rd32(v); check("R7 three ticks", v, 32'hBEEF_0F12);
    preset(32'h0000_FFFF);
    ticks(1);
    rd32(v); check("R7 carry", v, 32'h0001_0000);
    preset(32'hFFFF_FFFF);
    ticks(1);
    rd32(v); check("R7 wrap", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    preset(32'h0005_0005);
    wr(16'h0008, 16'h0001);
    wr(16'h0004, 16'h0010, 1);
    rd32(v); check("R8 accepted write wins", v, 32'h0005_0010);
    wr(16'h0000, 16'h0005);
    wr(16'h0004, 16'h0020, 1);
    rd32(v); check("R8 rejected write keeps tick", v, 32'h0005_0011);
  endtask

  task automatic t_preset;
    logic [31:0] v;
    preset(32'h1234_5678, 1);
    rd32(v); check("R11 preset over tick", v, 32'h1234_5678);
    wr(16'h0008, 16'h0001);
    preset(32'hCAFE_0000);
    wr(16'h0004, 16'h00AA);
    rd32(v); check("R11 flag unchanged", v, 32'hCAFE_00AA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_locked();
    t_lo_then_hi();
    t_ctrl();
    t_alias();
    t_tick();
    t_collide();
    t_preset();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule